// File: doc/BRIEF.md
# Transmit Byte Match-and-Substitute Filter

This block sits in a serial transmit path, between the byte store that holds outgoing characters and the transmitter that frames them. Each byte that passes through is checked against two programmable match values. Depending on a small set of enable bits, a matching byte is sent on unchanged, dropped, swapped for one substitute byte, or expanded into a pair of substitute bytes. Bytes that match nothing leave unchanged and in order.

Both sides use a valid/ready handshake. The output is registered. A second register holds the trailing byte of a two-byte expansion. The input is stalled while that trailing byte waits, so the output order always follows the input order. The configuration is sampled when a byte is accepted. The trailing byte of an expansion is captured at the same moment.

Top module: `tx_subst_filter`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: A byte that matches no enabled match value leaves unchanged. Match value A is tested only when mode bit 0 is 1. Match value B is tested only when mode bit 1 is 1.
- R3: When mode bit 2 is 1 and a byte equals enabled match value A, the byte is discarded and produces no output.
- R4: When mode bit 3 is 1 and a byte equals enabled match value B (and not enabled match value A), the byte is discarded.
- R5: When a byte equals enabled match value B (and not enabled match value A) and mode bit 3 is 0, the output is the single byte sub_b.
- R6: When mode bit 4 is 1, mode bit 2 is 0, and a byte equals enabled match value A, the output is sub_a_first followed by sub_a_second.
- R7: A byte that equals enabled match value A, with mode bits 2 and 4 both 0, leaves unchanged. When mode bits 2 and 4 are both 1, the discard of R3 applies.
- R8: If a byte equals both enabled match values, only the rules for match value A apply.
- R9: In the cycle after a byte that expands to two bytes is accepted, in_ready is 0. The two bytes appear back to back in the output order, before any later input byte.
- R10: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data stays unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte offered |
| in_data | input | DW | Input byte |
| in_ready | output | 1 | Filter can take a byte this cycle |
| out_valid | output | 1 | Output byte offered |
| out_data | output | DW | Output byte |
| out_ready | input | 1 | Transmitter takes the byte |
| mode | input | 5 | bit0 match-A enable, bit1 match-B enable, bit2 drop on A, bit3 drop on B, bit4 expand A to two bytes |
| match_a | input | DW | Match value A |
| match_b | input | DW | Match value B |
| sub_a_first | input | DW | First byte sent for an expanded A match |
| sub_a_second | input | DW | Second byte sent for an expanded A match |
| sub_b | input | DW | Substitute byte for a B match |

## Verification
The bench builds the block with the default byte width of 8. It sweeps all 32 settings of the mode field. Each setting is run with distinct match values and again with equal match values, so the A-over-B priority is reached. Every setting sees a byte stream that mixes both match values, repeated A matches and neutral bytes. Output backpressure alternates between a stalling pattern and free flow, which exercises the hold behaviour and the input stall during expansions.

// File: rtl/tx_subst_filter.sv
module tx_subst_filter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  input  logic          out_ready,
  input  logic [4:0]    mode,
  input  logic [DW-1:0] match_a,
  input  logic [DW-1:0] match_b,
  input  logic [DW-1:0] sub_a_first,
  input  logic [DW-1:0] sub_a_second,
  input  logic [DW-1:0] sub_b
);

  logic          pend_v;
  logic [DW-1:0] pend_d;

  wire hit_a   = mode[0] && (in_data == match_a);
  wire hit_b   = !hit_a && mode[1] && (in_data == match_b);
  wire drop    = (hit_a && mode[2]) || (hit_b && mode[3]);
  wire expand  = hit_a && !mode[2] && mode[4];
  wire out_free = !out_valid || out_ready;
  wire take    = in_valid && in_ready;

  logic [DW-1:0] first_byte;
  always_comb begin
    first_byte = in_data;
    if (expand)     first_byte = sub_a_first;
    else if (hit_b) first_byte = sub_b;
  end

  assign in_ready = !pend_v && out_free;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      pend_v    <= 1'b0;
      pend_d    <= '0;
    end else if (pend_v && out_free) begin
      out_valid <= 1'b1;
      out_data  <= pend_d;
      pend_v    <= 1'b0;
    end else if (take) begin
      out_valid <= !drop;
      if (!drop) out_data <= first_byte;
      pend_v    <= expand;
      pend_d    <= sub_a_second;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R9
  expand_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && mode[0] && !mode[2] && mode[4] && in_data == match_a
    |=> !in_ready && out_valid && out_data == $past(sub_a_first));

  // R3
  drop_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && mode[0] && mode[2] && in_data == match_a |=> !out_valid);

  // R4
  drop_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !(mode[0] && in_data == match_a)
    && mode[1] && mode[3] && in_data == match_b |=> !out_valid);

  // R5
  swap_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !(mode[0] && in_data == match_a)
    && mode[1] && !mode[3] && in_data == match_b
    |=> out_valid && out_data == $past(sub_b));

endmodule

// File: tb/tx_subst_filter_bench.sv
module tx_subst_filter_bench;
  localparam int PERIOD = 10;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic in_ready, out_valid, out_ready;
  logic [DW-1:0] out_data;
  logic [4:0] mode = '0;
  logic [DW-1:0] match_a = 8'h11, match_b = 8'h22;
  logic [DW-1:0] sub_a_first = 8'hA1, sub_a_second = 8'hB2, sub_b = 8'hC3;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];

  always #(PERIOD/2) clk = ~clk;

  tx_subst_filter #(.DW(DW)) u_tx_subst_filter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .mode(mode), .match_a(match_a), .match_b(match_b),
    .sub_a_first(sub_a_first), .sub_a_second(sub_a_second), .sub_b(sub_b));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h mode=%05b", req, act, exp, mode);
    end
  endtask

  task automatic model(input logic [DW-1:0] b, output int n);
    bit ha, hb;
    ha = mode[0] && b == match_a;
    hb = !ha && mode[1] && b == match_b;
    n = 0;
    if (ha) begin
      string t;
      t = (mode[1] && match_a == match_b) ? "R8" : "";
      if (mode[2]) n = 0;
      else if (mode[4]) begin
        exp_q.push_back(sub_a_first);  tag_q.push_back({"R6 ", t});
        exp_q.push_back(sub_a_second); tag_q.push_back({"R6 ", t});
        n = 2;
      end else begin
        exp_q.push_back(b); tag_q.push_back({"R7 ", t}); n = 1;
      end
    end else if (hb) begin
      if (!mode[3]) begin exp_q.push_back(sub_b); tag_q.push_back("R5"); n = 1; end
    end else begin
      exp_q.push_back(b); tag_q.push_back("R2"); n = 1;
    end
  endtask

  int cyc = 0;
  bit prev_hold = 0;
  logic [DW-1:0] prev_data = '0;
  bit expect_stall = 0;

  task automatic step(input bit stall_pat);
    out_ready = stall_pat ? (cyc % 3 != 2) : 1'b1;
    #1;
    if (prev_hold) begin
      check(out_valid == 1'b1 && out_data == prev_data, "R10", out_data, prev_data);
    end
    if (expect_stall) check(in_ready == 1'b0, "R9", in_ready, 0);
    expect_stall = 0;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) check(1'b0, "R3/R4 extra output", out_data, 0);
      else begin
        logic [DW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(out_data == e, t, out_data, e);
      end
    end
    prev_hold = out_valid && !out_ready;
    prev_data = out_data;
    cyc++;
  endtask

  task automatic run_stream(input bit stall_pat);
    logic [DW-1:0] bytes[7];
    bytes = '{match_a, match_b, 8'h5A, match_a, match_a, 8'h00, match_b};
    foreach (bytes[i]) begin
      bit done;
      done = 0;
      while (!done) begin
        @(negedge clk);
        in_valid = 1'b1;
        in_data = bytes[i];
        step(stall_pat);
        if (in_ready) begin
          int n;
          model(bytes[i], n);
          if (n == 2) expect_stall = 1;
          done = 1;
        end
      end
    end
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      step(stall_pat);
    end
    check(exp_q.size() == 0, "R9 order/count", exp_q.size(), 0);
    exp_q.delete();
    tag_q.delete();
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    out_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R1", out_valid, 0);
    check(in_ready == 1'b1, "R1", in_ready, 1);
    rst_n = 1'b1;
    for (int eqm = 0; eqm < 2; eqm++) begin
      match_a = eqm ? 8'h33 : 8'h11;
      match_b = eqm ? 8'h33 : 8'h22;
      for (int m = 0; m < 32; m++) begin
        mode = m[4:0];
        run_stream(1'b1);
        run_stream(1'b0);
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule